// File: doc/BRIEF.md
# Performance Monitor Counter Unit

This block counts activity for profiling. It holds a free-running cycle counter and two event counters, each 32 bits wide. All three are steered by one 32-bit control word. Each event counter watches one bit of a 32-bit event input vector, and the control word chooses that bit with an 8-bit selector. A counter that wraps past its maximum sets a sticky overflow flag. The interrupt line is raised while any flag is set whose reporting is enabled. The two selected event bits can also be passed out on a two-bit event bus, so that an external observer can see them.

Software reaches the unit through a simple synchronous port with a write strobe and a two-bit address. A write takes effect on the clock edge. A read is combinational from the address. Address 0 is the control word, address 1 is the cycle counter, address 2 is event counter 0 and address 3 is event counter 1. The cycle counter can be slowed by a fixed divide-by-64 prescaler. The prescaler restarts from zero on every control write, so software can align its measurement windows.

Top module: `pmu_counter_unit`

## Requirements
- R1: After reset, the control word, all three counters, the interrupt and the event bus read 0.
- R2: Control bit 0 is a global run enable. While it is 0, none of the three counters changes, except by a direct load.
- R3: With control bit 3 at 0, the cycle counter advances on every clock. With bit 3 at 1, it advances only when a 6-bit prescaler has reached 63, which is once per 64 clocks. Every write to the control word resets the prescaler to 0.
- R4: Event counter 0 takes its selector from control bits [27:20], and event counter 1 from bits [19:12]. A selector N below 32 makes the counter advance on each clock where events_i[N] is 1. A selector of 32 or more never counts.
- R5: When a counter wraps from 0xFFFFFFFF to 0, its overflow flag is set. The flags are bit 8 for counter 0, bit 9 for counter 1 and bit 10 for the cycle counter.
- R6: Writing 1 to a flag bit clears that flag, and writing 0 leaves it unchanged. If a wrap and a clear happen in the same cycle, the flag ends up set.
- R7: Interrupt enables sit in bit 4 for counter 0, bit 5 for counter 1 and bit 6 for the cycle counter. irq_o is 1 exactly when some flag and its enable are both 1.
- R8: When control bit 11 is 1, evt_bus_o[0] carries the event bit selected for counter 0 and evt_bus_o[1] carries the bit selected for counter 1. When bit 11 is 0, the bus is 0.
- R9: A write to address 1, 2 or 3 loads the cycle counter, event counter 0 or event counter 1 with the written value. In that cycle the load takes precedence over any increment, and the load never sets a flag.
- R10: Address 0 reads back the control word. Bits [31:28], 7, 2 and 1 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside the unit |
| wr_en_i | input | 1 | Write strobe for the addressed register |
| addr_i | input | 2 | Register address: 0 control, 1 cycle counter, 2 counter 0, 3 counter 1 |
| wr_data_i | input | 32 | Write data |
| rd_data_o | output | 32 | Combinational read data of the addressed register |
| events_i | input | EVT_W | Event input vector |
| evt_bus_o | output | 2 | Exported selected events: bit 0 for counter 0, bit 1 for counter 1 |
| irq_o | output | 1 | Level-sensitive overflow interrupt |

## Verification
A wrong prescaler phase becomes visible as a cycle-counter read that is off by one at the exact cycle when a divided tick is due, which is at most 64 clocks after the fault. A wrong selector, a mis-decoded load or a lost flag shows up on the very next read of that address or on irq_o in the following cycle. The reference model is compared with the read data, the event bus and the interrupt on every clock, so such a fault is reported in the cycle where it first reaches a port. Directed runs steer counters to just below the wrap point, which makes wraps, set-versus-clear collisions and load-versus-increment collisions happen within a few cycles.

// File: rtl/pmu_pkg.sv
package pmu_pkg;
  localparam int CNT_W = 32;
  localparam int SEL_W = 8;
  localparam int NUM_EVT = 2;

  typedef enum logic [1:0] {
    A_CTRL = 2'd0,
    A_CYC  = 2'd1,
    A_CNT0 = 2'd2,
    A_CNT1 = 2'd3
  } pmu_addr_e;

  // control word bit positions (decoded by software)
  localparam int B_EN      = 0;
  localparam int B_DIV     = 3;
  localparam int B_IE_LO   = 4;
  localparam int B_FLAG_LO = 8;
  localparam int B_EXPORT  = 11;
  localparam int B_SEL1_LO = 12;
  localparam int B_SEL0_LO = 20;

  // flag/enable index inside the 3-bit groups
  localparam int IX_C0  = 0;
  localparam int IX_C1  = 1;
  localparam int IX_CYC = 2;
endpackage

// File: rtl/pmu_event_pick.sv
module pmu_event_pick #(
  parameter int EVT_W = 32,
  parameter int SEL_W = 8
) (
  input  logic [EVT_W-1:0] events_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             hit_o
);
  localparam int IW = (EVT_W > 1) ? $clog2(EVT_W) : 1;

  always_comb begin
    hit_o = 1'b0;
    if (32'(sel_i) < EVT_W) hit_o = events_i[sel_i[IW-1:0]];
  end
endmodule

// File: rtl/pmu_prescaler.sv
module pmu_prescaler #(
  parameter int DIV_LOG2 = 6
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic clr_i,
  output logic tick_o
);
  logic [DIV_LOG2-1:0] pre_q, pre_d;

  always_comb begin
    pre_d = pre_q;
    if (clr_i)      pre_d = '0;
    else if (run_i) pre_d = pre_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pre_q <= '0;
    else         pre_q <= pre_d;
  end

  assign tick_o = run_i && (pre_q == '1);

  // R3: a control write restarts the divider
  a_r3_pre_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (pre_q == '0));
  a_r3_pre_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !run_i) |=> $stable(pre_q));
endmodule

// File: rtl/pmu_wrap_counter.sv
module pmu_wrap_counter #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         inc_i,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic [W-1:0] count_o,
  output logic         wrap_o
);
  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load_i)     cnt_d = load_val_i;
    else if (inc_i) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign count_o = cnt_q;
  assign wrap_o  = inc_i && !load_i && (cnt_q == '1);

  // R9: load beats increment
  a_r9_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (cnt_q == $past(load_val_i)));
  // R5: wrap lands on zero
  a_r5_wrap_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_o |=> (cnt_q == '0));
  // R2: no advance without a request
  a_r2_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!inc_i && !load_i) |=> $stable(cnt_q));
endmodule

// File: rtl/pmu_counter_unit.sv
module pmu_counter_unit
  import pmu_pkg::*;
#(
  parameter int EVT_W    = 32,
  parameter int DIV_LOG2 = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [1:0]       addr_i,
  input  logic [31:0]      wr_data_i,
  output logic [31:0]      rd_data_o,
  input  logic [EVT_W-1:0] events_i,
  output logic [1:0]       evt_bus_o,
  output logic             irq_o
);
  // reset: asynchronous assertion, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_sn;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= '0;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sn = rst_sync_q[1];

  // write decode
  logic ctrl_wr, cyc_ld;
  logic [NUM_EVT-1:0] evt_ld;
  assign ctrl_wr   = wr_en_i && (addr_i == A_CTRL);
  assign cyc_ld    = wr_en_i && (addr_i == A_CYC);
  assign evt_ld[0] = wr_en_i && (addr_i == A_CNT0);
  assign evt_ld[1] = wr_en_i && (addr_i == A_CNT1);

  // control state
  logic             en_q, en_d;
  logic             div_q, div_d;
  logic             exp_q, exp_d;
  logic [2:0]       ie_q, ie_d;
  logic [2:0]       flag_q, flag_d;
  logic [SEL_W-1:0] sel_q [NUM_EVT];
  logic [SEL_W-1:0] sel_d [NUM_EVT];

  // counters
  logic [CNT_W-1:0] cyc_cnt;
  logic             cyc_tick, cyc_wrap;
  logic [CNT_W-1:0] evt_cnt [NUM_EVT];
  logic [NUM_EVT-1:0] evt_hit, evt_wrap;

  pmu_prescaler #(.DIV_LOG2(DIV_LOG2)) u_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_sn),
    .run_i  (en_q && div_q),
    .clr_i  (ctrl_wr),
    .tick_o (cyc_tick)
  );

  pmu_wrap_counter #(.W(CNT_W)) u_cyc (
    .clk_i      (clk_i),
    .rst_ni     (rst_sn),
    .inc_i      (en_q && (!div_q || cyc_tick)),
    .load_i     (cyc_ld),
    .load_val_i (wr_data_i),
    .count_o    (cyc_cnt),
    .wrap_o     (cyc_wrap)
  );

  for (genvar g = 0; g < NUM_EVT; g++) begin : g_evt
    pmu_event_pick #(.EVT_W(EVT_W), .SEL_W(SEL_W)) u_pick (
      .events_i (events_i),
      .sel_i    (sel_q[g]),
      .hit_o    (evt_hit[g])
    );
    pmu_wrap_counter #(.W(CNT_W)) u_cnt (
      .clk_i      (clk_i),
      .rst_ni     (rst_sn),
      .inc_i      (en_q && evt_hit[g]),
      .load_i     (evt_ld[g]),
      .load_val_i (wr_data_i),
      .count_o    (evt_cnt[g]),
      .wrap_o     (evt_wrap[g])
    );
  end

  // next-state for control word
  logic [2:0] flag_set, flag_clr;
  always_comb begin
    flag_set         = '0;
    flag_set[IX_C0]  = evt_wrap[0];
    flag_set[IX_C1]  = evt_wrap[1];
    flag_set[IX_CYC] = cyc_wrap;
    flag_clr = ctrl_wr ? wr_data_i[B_FLAG_LO +: 3] : 3'b000;
    flag_d   = flag_set | (flag_q & ~flag_clr);

    en_d     = en_q;
    div_d    = div_q;
    exp_d    = exp_q;
    ie_d     = ie_q;
    sel_d[0] = sel_q[0];
    sel_d[1] = sel_q[1];
    if (ctrl_wr) begin
      en_d     = wr_data_i[B_EN];
      div_d    = wr_data_i[B_DIV];
      exp_d    = wr_data_i[B_EXPORT];
      ie_d     = wr_data_i[B_IE_LO +: 3];
      sel_d[0] = wr_data_i[B_SEL0_LO +: SEL_W];
      sel_d[1] = wr_data_i[B_SEL1_LO +: SEL_W];
    end
  end

  always_ff @(posedge clk_i or negedge rst_sn) begin
    if (!rst_sn) begin
      en_q     <= 1'b0;
      div_q    <= 1'b0;
      exp_q    <= 1'b0;
      ie_q     <= '0;
      flag_q   <= '0;
      sel_q[0] <= '0;
      sel_q[1] <= '0;
    end else begin
      en_q     <= en_d;
      div_q    <= div_d;
      exp_q    <= exp_d;
      ie_q     <= ie_d;
      flag_q   <= flag_d;
      sel_q[0] <= sel_d[0];
      sel_q[1] <= sel_d[1];
    end
  end

  // read mux
  logic [31:0] ctrl_rd;
  always_comb begin
    ctrl_rd                        = '0;
    ctrl_rd[B_EN]                  = en_q;
    ctrl_rd[B_DIV]                 = div_q;
    ctrl_rd[B_IE_LO +: 3]          = ie_q;
    ctrl_rd[B_FLAG_LO +: 3]        = flag_q;
    ctrl_rd[B_EXPORT]              = exp_q;
    ctrl_rd[B_SEL1_LO +: SEL_W]    = sel_q[1];
    ctrl_rd[B_SEL0_LO +: SEL_W]    = sel_q[0];
  end

  always_comb begin
    unique case (pmu_addr_e'(addr_i))
      A_CTRL:  rd_data_o = ctrl_rd;
      A_CYC:   rd_data_o = cyc_cnt;
      A_CNT0:  rd_data_o = evt_cnt[0];
      default: rd_data_o = evt_cnt[1];
    endcase
  end

  assign evt_bus_o = exp_q ? evt_hit : 2'b00;
  assign irq_o     = |(flag_q & ie_q);

  // R6: a wrap always leaves its flag set, even against a clear
  a_r6_set_wins: assert property (@(posedge clk_i) disable iff (!rst_sn)
    evt_wrap[0] |=> flag_q[IX_C0]);
  a_r6_cyc_set_wins: assert property (@(posedge clk_i) disable iff (!rst_sn)
    cyc_wrap |=> flag_q[IX_CYC]);
  // R6: flags only fall on a control write
  a_r6_sticky: assert property (@(posedge clk_i) disable iff (!rst_sn)
    !ctrl_wr |=> ((flag_q & $past(flag_q)) == $past(flag_q)));
  // R7: no interrupt with reporting disabled
  a_r7_irq_quiet: assert property (@(posedge clk_i) disable iff (!rst_sn)
    (ie_q == 3'b000) |-> !irq_o);
  // R8: bus gated by export enable
  a_r8_bus_gate: assert property (@(posedge clk_i) disable iff (!rst_sn)
    !exp_q |-> (evt_bus_o == 2'b00));
  // R2: frozen counters while disabled and not written
  a_r2_frozen: assert property (@(posedge clk_i) disable iff (!rst_sn)
    (!en_q && !wr_en_i) |=> $stable({cyc_cnt, evt_cnt[0], evt_cnt[1]}));
endmodule

// File: tb/tb_pmu_counter_unit.sv
module tb_pmu_counter_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        we;
  logic [1:0]  addr;
  logic [31:0] wd;
  logic [31:0] ev;
  logic [31:0] rd_data;
  logic [1:0]  evt_bus;
  logic        irq;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pmu_counter_unit dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(we), .addr_i(addr),
    .wr_data_i(wd), .rd_data_o(rd_data), .events_i(ev),
    .evt_bus_o(evt_bus), .irq_o(irq)
  );

  // behavioural reference model
  logic [31:0] m_cyc, m_c0, m_c1;
  int          m_pre;
  bit          m_en, m_div, m_exp;
  bit   [2:0]  m_ie, m_flag;
  logic [7:0]  m_s0, m_s1;

  function automatic bit pick(logic [7:0] s, logic [31:0] e);
    if (s < 8'd32) return e[s[4:0]];
    return 1'b0;
  endfunction

  function automatic logic [31:0] m_ctrl();
    return {4'h0, m_s0, m_s1, m_exp, m_flag, 1'b0, m_ie, m_div, 2'b00, m_en};
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cyc = 0; m_c0 = 0; m_c1 = 0; m_pre = 0;
      m_en = 0; m_div = 0; m_exp = 0; m_ie = 0; m_flag = 0; m_s0 = 0; m_s1 = 0;
    end else begin
      bit cw, lc, l0, l1, tc, i0, i1;
      bit [2:0] st, cl;
      cw = we && addr == 2'd0;
      lc = we && addr == 2'd1;
      l0 = we && addr == 2'd2;
      l1 = we && addr == 2'd3;
      tc = m_en && (!m_div || m_pre == 63);
      i0 = m_en && pick(m_s0, ev);
      i1 = m_en && pick(m_s1, ev);
      st[0] = i0 && !l0 && m_c0 == 32'hFFFF_FFFF;
      st[1] = i1 && !l1 && m_c1 == 32'hFFFF_FFFF;
      st[2] = tc && !lc && m_cyc == 32'hFFFF_FFFF;
      cl = cw ? wd[10:8] : 3'b000;
      m_flag = st | (m_flag & ~cl);
      m_cyc = lc ? wd : (tc ? m_cyc + 1 : m_cyc);
      m_c0  = l0 ? wd : (i0 ? m_c0 + 1 : m_c0);
      m_c1  = l1 ? wd : (i1 ? m_c1 + 1 : m_c1);
      if (cw) m_pre = 0;
      else if (m_en && m_div) m_pre = (m_pre + 1) % 64;
      if (cw) begin
        m_en = wd[0]; m_div = wd[3]; m_ie = wd[6:4]; m_exp = wd[11];
        m_s1 = wd[19:12]; m_s0 = wd[27:20];
      end
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one cycle: drive at negedge, compare all outputs with the model
  task automatic tick(bit w, logic [1:0] a, logic [31:0] d, logic [31:0] e);
    @(negedge clk);
    we = w; addr = a; wd = d; ev = e;
    #1;
    case (a)
      2'd0: chk("R10 read ctrl", rd_data, m_ctrl());
      2'd1: chk("R3 read cycle counter", rd_data, m_cyc);
      2'd2: chk("R4 read counter0", rd_data, m_c0);
      default: chk("R4 read counter1", rd_data, m_c1);
    endcase
    chk("R7 irq", {31'b0, irq}, {31'b0, |(m_flag & m_ie)});
    chk("R8 event bus", {30'b0, evt_bus},
        {30'b0, m_exp ? {pick(m_s1, ev), pick(m_s0, ev)} : 2'b00});
  endtask

  task automatic rdchk(logic [1:0] a, logic [31:0] exp, string tag);
    tick(0, a, 0, 0);
    chk(tag, rd_data, exp);
  endtask

  task automatic idle(int n, logic [31:0] e);
    for (int i = 0; i < n; i++) tick(0, 2'd0, 0, e);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rst_n = 0; we = 0; addr = 0; wd = 0; ev = 0;
    repeat (4) @(posedge clk);
    @(negedge clk); rst_n = 1;

    rdchk(0, 0, "R1 ctrl reset");
    rdchk(1, 0, "R1 cycle reset");
    rdchk(2, 0, "R1 cnt0 reset");
    rdchk(3, 0, "R1 cnt1 reset");
    chk("R1 irq reset", {31'b0, irq}, 0);

    idle(10, 32'hFFFF_FFFF);
    rdchk(1, 0, "R2 disabled cycle");
    rdchk(2, 0, "R2 disabled cnt0");

    tick(1, 0, 32'h1, 0);
    idle(10, 0);
    rdchk(1, 10, "R3 every clock");

    tick(1, 0, 0, 0);
    tick(1, 1, 0, 0);
    tick(1, 0, 32'h9, 0);
    idle(63, 0);
    rdchk(1, 0, "R3 div before tick");
    rdchk(1, 1, "R3 div after 64");
    idle(30, 0);
    tick(1, 0, 32'h9, 0);
    idle(63, 0);
    rdchk(1, 1, "R3 prescaler restart");
    rdchk(1, 2, "R3 prescaler restart tick");

    tick(1, 0, 0, 0);
    tick(1, 2, 0, 0);
    tick(1, 3, 0, 0);
    tick(1, 0, 32'h0052_8801, 0);
    for (int i = 0; i < 7; i++) begin
      tick(0, 0, 0, 32'hFFFF_FFFF);
      chk("R8 export on", {30'b0, evt_bus}, 32'd1);
    end
    rdchk(2, 7, "R4 select bit5");
    rdchk(3, 0, "R4 select 40 never counts");
    for (int i = 0; i < 4; i++) tick(0, 0, 0, (i % 2 == 0) ? 32'h20 : 32'hFFFF_FFDF);
    rdchk(2, 9, "R4 alternating");
    tick(1, 0, 32'h0052_8001, 0);
    tick(0, 0, 0, 32'hFFFF_FFFF);
    chk("R8 export off", {30'b0, evt_bus}, 0);

    tick(1, 0, 0, 0);
    tick(1, 2, 32'hFFFF_FFFE, 0);
    tick(1, 0, 32'h0050_0011, 0);
    tick(0, 0, 0, 32'h20);
    tick(0, 0, 0, 32'h20);
    rdchk(0, 32'h0050_0111, "R5 flag bit8 set");
    chk("R7 irq raised", {31'b0, irq}, 1);
    rdchk(2, 0, "R5 wrapped to zero");

    tick(1, 0, 32'h0050_0011, 0);
    rdchk(0, 32'h0050_0111, "R6 write0 keeps flag");
    tick(1, 0, 32'h0050_0111, 0);
    rdchk(0, 32'h0050_0011, "R6 write1 clears");
    chk("R7 irq dropped", {31'b0, irq}, 0);
    tick(1, 2, 32'hFFFF_FFFF, 0);
    tick(1, 0, 32'h0050_0111, 32'h20);
    rdchk(0, 32'h0050_0111, "R6 set wins");
    tick(1, 0, 32'h0050_0001, 0);
    rdchk(0, 32'h0050_0101, "R7 enable off");
    chk("R7 irq masked", {31'b0, irq}, 0);

    tick(1, 2, 32'd123, 32'h20);
    rdchk(2, 123, "R9 load beats increment");
    tick(1, 0, 32'h0050_0101, 0);
    tick(1, 2, 32'hFFFF_FFFF, 0);
    tick(1, 2, 32'hFFFF_FFFF, 32'h20);
    rdchk(0, 32'h0050_0001, "R9 load sets no flag");
    rdchk(2, 32'hFFFF_FFFF, "R9 loaded value");

    tick(1, 0, 32'hFFFF_FFFF, 0);
    rdchk(0, 32'h0FFF_F879, "R10 reserved read zero");

    for (int i = 0; i < 4000; i++) begin
      int r;
      logic [31:0] d;
      r = $urandom_range(0, 19);
      if (r == 0) begin
        d = $urandom;
        d[27:20] = 8'($urandom_range(0, 40));
        d[19:12] = 8'($urandom_range(0, 40));
        d[3] = ($urandom_range(0, 7) == 0);
        d[0] = ($urandom_range(0, 5) != 0);
        tick(1, 0, d, $urandom);
      end else if (r == 1) begin
        tick(1, 2'($urandom_range(1, 3)), 32'hFFFF_FFF0 | 32'($urandom_range(0, 15)), $urandom);
      end else begin
        tick(0, 2'($urandom_range(0, 3)), 0, $urandom);
      end
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule